// File: doc/BRIEF.md
# Busy/Result Handshake Encoder for a Single-Wire Bus Master

This block sits between a host's parallel status lines and a single-wire bus timing generator. It drives two status outputs, `out1` and `out2`. Those lines normally mirror two pass-through inputs from a device further down the chain, such as a printer or another bus master. A falling edge on the active-low enable `en_n` captures a command from the `dclk` and `rsel` lines. The command is one of four:

- a bit slot with the data line high (read, or write 1);
- a write-0 bit slot;
- a bus reset;
- a toggle of the overdrive mode bit.

For the three bus commands, the block pulses `slot_go` to the timing generator. While the slot runs, the block shows a busy code on the two outputs. A reset slot first shows a short split code (`out1` low, `out2` high) so the host can tell it apart from a bit slot. A bit slot drives both outputs low at once.

When the timing generator drops `tg_busy`, the block captures `tg_result` and lets the inputs pass through again. The host then pulls `dclk` low to query the result. A low result is shown as both outputs low until `en_n` rises. A high result lets the inputs keep passing through.

When the device is the last one in the chain (`last_dev`), the pass-through inputs are read as high while `en_n` is low. All inputs are taken to be synchronous to `clk`.

Top module: `busy_result_encoder`

## Requirements
- R1: Command capture happens at the first clock edge at which `en_n` is low after being high. The command is decoded from (`rsel`,`dclk`) as follows: (1,1) is a bit slot with data high, code 0; (1,0) is a write-0 slot, code 1; (0,1) is a bus reset, code 2; (0,0) is an overdrive toggle, code 3. For codes 0 to 2, `slot_go` is high for exactly the one cycle after that edge, and `slot_cmd` carries the code.
- R2: For a reset command, the outputs are `out1`=0 and `out2`=1 for exactly SPLIT_CYC cycles, starting at the capture edge. After that, both outputs are 0 until the slot completes.
- R3: For a bit command (code 0 or 1), both outputs are 0 from the capture edge until the slot completes.
- R4: A slot completes at the first edge at which `tg_busy` is low after it has been seen high during the slot. From then on, the outputs follow the pass-through inputs, and `tg_result` at that edge is kept as the slot result.
- R5: After completion, once an edge sees `dclk` low, the outputs behave according to the kept result. If the result is 0, both outputs are 0 until `en_n` rises. If the result is 1, the outputs follow the pass-through inputs.
- R6: When the block is not in a slot and `en_n` is high, `out1`/`out2` equal `pass1`/`pass2` combinationally. Raising `en_n` after a completed slot or a toggle returns the block to this state at the next edge.
- R7: An overdrive toggle inverts `od_mode` and produces no `slot_go`. Afterwards, the outputs follow the pass-through inputs if `od_mode` is now 1, and are both 0 if it is now 0.
- R8: With `last_dev` high and `en_n` low, the pass-through inputs are treated as 1 wherever they would be shown.
- R9: A new falling edge on `en_n` while a slot is in progress is ignored: there is no `slot_go`, no change of `od_mode`, and the busy code stays unchanged.
- R10: Synchronous reset sets `od_mode` to 0 and `slot_go` to 0, and leaves the outputs following the pass-through inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low host enable; a falling edge starts a command |
| dclk | input | 1 | Data/clock line: part of the command, and pulled low to query the result |
| rsel | input | 1 | Reset-select line, part of the command |
| pass1 | input | 1 | Pass-through input for status output 1 |
| pass2 | input | 1 | Pass-through input for status output 2 |
| last_dev | input | 1 | High when this device is the last one in the chain |
| tg_busy | input | 1 | Timing generator busy |
| tg_result | input | 1 | Sampled bus bit from the timing generator |
| out1 | output | 1 | Status output 1 |
| out2 | output | 1 | Status output 2 |
| od_mode | output | 1 | Overdrive mode bit, sent to the timing generator |
| slot_go | output | 1 | One-cycle start pulse for the timing generator |
| slot_cmd | output | 2 | Code of the captured command |

## Verification
Results fall due at three different times:

- Pass-through when idle is combinational. The bench changes `pass1`/`pass2` and checks 1 ns later, with no clock edge in between.
- Every state-driven result (capture, busy code, completion, query, toggle, return to idle) is due one clock edge after the stimulus. The bench drives on a falling clock edge and checks on the next falling edge.
- For the reset split code, the bench checks `out2` high after SPLIT_CYC-1 further cycles and low after one more, which pins down both ends of the window. Random commands, results, last-device settings and pass-through values are mixed with a directed reset check and a check of ignored re-triggering.

// File: rtl/bre_pkg.sv
package bre_pkg;

    typedef enum logic [1:0] {
        CMD_BIT_HI  = 2'd0,
        CMD_WR_LO   = 2'd1,
        CMD_BUS_RST = 2'd2,
        CMD_OD_TOG  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SPLIT = 3'd1,
        ST_BUSY  = 3'd2,
        ST_DONE  = 3'd3,
        ST_QUERY = 3'd4,
        ST_ODREP = 3'd5
    } state_e;

    typedef struct packed {
        logic o1;
        logic o2;
    } pair_t;

    // Map (reset-select, data/clock) onto a command code.
    function automatic cmd_e decode_cmd(input logic dclk, input logic rsel);
        case ({rsel, dclk})
            2'b11:   return CMD_BIT_HI;
            2'b10:   return CMD_WR_LO;
            2'b01:   return CMD_BUS_RST;
            default: return CMD_OD_TOG;
        endcase
    endfunction

    // Pass-through value, forced high for the last device while enabled.
    function automatic pair_t eff_pass(input logic p1, input logic p2,
                                       input logic last, input logic en_n);
        pair_t r;
        if (last && !en_n) begin
            r.o1 = 1'b1;
            r.o2 = 1'b1;
        end else begin
            r.o1 = p1;
            r.o2 = p2;
        end
        return r;
    endfunction

endpackage

// File: rtl/bre_cmd_capture.sv
module bre_cmd_capture
    import bre_pkg::*;
(
    input  logic clk,
    input  logic en_n,
    input  logic dclk,
    input  logic rsel,
    output logic fall,
    output cmd_e cmd
);
    logic en_q;

    // Tracks the enable line during reset as well, so that no false edge
    // appears when reset is released.
    always_ff @(posedge clk) begin
        en_q <= en_n;
    end

    assign fall = en_q & ~en_n;
    assign cmd  = decode_cmd(dclk, rsel);

endmodule

// File: rtl/bre_split_timer.sv
module bre_split_timer #(
    parameter int SPLIT_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(SPLIT_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SPLIT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run && (cnt_q == '0);

endmodule

// File: rtl/bre_out_mux.sv
module bre_out_mux
    import bre_pkg::*;
(
    input  state_e st,
    input  logic   res,
    input  logic   od,
    input  pair_t  pass,
    output pair_t  drive
);
    localparam pair_t LOW   = '{o1: 1'b0, o2: 1'b0};
    localparam pair_t SPLIT = '{o1: 1'b0, o2: 1'b1};

    always_comb begin
        case (st)
            ST_SPLIT: drive = SPLIT;
            ST_BUSY:  drive = LOW;
            ST_QUERY: drive = res ? pass : LOW;
            ST_ODREP: drive = od ? pass : LOW;
            default:  drive = pass;
        endcase
    end

endmodule

// File: rtl/busy_result_encoder.sv
module busy_result_encoder
    import bre_pkg::*;
#(
    parameter int SPLIT_CYC = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_n,
    input  logic       dclk,
    input  logic       rsel,
    input  logic       pass1,
    input  logic       pass2,
    input  logic       last_dev,
    input  logic       tg_busy,
    input  logic       tg_result,
    output logic       out1,
    output logic       out2,
    output logic       od_mode,
    output logic       slot_go,
    output logic [1:0] slot_cmd
);
    state_e st_q;
    cmd_e   cmd_q;
    cmd_e   cmd_in;
    logic   fall;
    logic   od_q, seen_q, res_q, go_q;
    logic   split_exp;
    pair_t  pass_eff, drive;

    bre_cmd_capture u_cap (
        .clk  (clk),
        .en_n (en_n),
        .dclk (dclk),
        .rsel (rsel),
        .fall (fall),
        .cmd  (cmd_in)
    );

    bre_split_timer #(.SPLIT_CYC(SPLIT_CYC)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (st_q == ST_IDLE && fall && cmd_in == CMD_BUS_RST),
        .run     (st_q == ST_SPLIT),
        .expired (split_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cmd_q  <= CMD_BIT_HI;
            od_q   <= 1'b0;
            seen_q <= 1'b0;
            res_q  <= 1'b1;
            go_q   <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (fall) begin
                        cmd_q <= cmd_in;
                        if (cmd_in == CMD_OD_TOG) begin
                            od_q <= ~od_q;
                            st_q <= ST_ODREP;
                        end else begin
                            go_q   <= 1'b1;
                            seen_q <= 1'b0;
                            st_q   <= (cmd_in == CMD_BUS_RST) ? ST_SPLIT : ST_BUSY;
                        end
                    end
                end
                ST_SPLIT: begin
                    if (tg_busy) seen_q <= 1'b1;
                    if (split_exp) st_q <= ST_BUSY;
                end
                ST_BUSY: begin
                    if (tg_busy) begin
                        seen_q <= 1'b1;
                    end else if (seen_q) begin
                        res_q <= tg_result;
                        st_q  <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (en_n)      st_q <= ST_IDLE;
                    else if (!dclk) st_q <= ST_QUERY;
                end
                ST_QUERY, ST_ODREP: begin
                    if (en_n) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign pass_eff = eff_pass(pass1, pass2, last_dev, en_n);

    bre_out_mux u_mux (
        .st    (st_q),
        .res   (res_q),
        .od    (od_q),
        .pass  (pass_eff),
        .drive (drive)
    );

    assign out1     = drive.o1;
    assign out2     = drive.o2;
    assign od_mode  = od_q;
    assign slot_go  = go_q;
    assign slot_cmd = cmd_q;

endmodule

// File: rtl/bre_checker.sv
module bre_checker
    import bre_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       en_n,
    input logic       pass1,
    input logic       pass2,
    input logic       last_dev,
    input logic       out1,
    input logic       out2,
    input logic       od_mode,
    input logic       slot_go,
    input logic [1:0] slot_cmd,
    input state_e     st
);
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        slot_go |=> !slot_go); // R1
    AST_RST_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (slot_go && slot_cmd == 2'd2) |-> (!out1 && out2)); // R2
    AST_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (slot_go && !slot_cmd[1]) |-> (!out1 && !out2)); // R3
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && en_n) |-> (out1 == pass1 && out2 == pass2)); // R6
    AST_NO_GO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        slot_go |-> (slot_cmd != 2'd3)); // R7
    AST_OD_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(od_mode) |-> (!$past(en_n) && $past(en_n, 2))); // R7
    AST_LAST_MASK: assert property (@(posedge clk) disable iff (rst)
        (last_dev && !en_n && st == ST_DONE) |-> (out1 && out2)); // R8
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && $past(st) == ST_BUSY) |-> (!slot_go && $stable(od_mode))); // R9
endmodule

bind busy_result_encoder bre_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .en_n     (en_n),
    .pass1    (pass1),
    .pass2    (pass2),
    .last_dev (last_dev),
    .out1     (out1),
    .out2     (out2),
    .od_mode  (od_mode),
    .slot_go  (slot_go),
    .slot_cmd (slot_cmd),
    .st       (st_q)
);

// File: tb/test_busy_result_encoder.sv
`timescale 1ns/1ps
module test_busy_result_encoder;
    localparam int SPLIT = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_n = 1'b1, dclk = 1'b1, rsel = 1'b1;
    logic pass1 = 1'b1, pass2 = 1'b1, last_dev = 1'b0;
    logic tg_busy = 1'b0, tg_result = 1'b1;
    logic out1, out2, od_mode, slot_go;
    logic [1:0] slot_cmd;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic exp_od = 1'b0;

    always #4 clk = ~clk;

    busy_result_encoder #(.SPLIT_CYC(SPLIT)) i_busy_result_encoder (
        .clk(clk), .rst(rst), .en_n(en_n), .dclk(dclk), .rsel(rsel),
        .pass1(pass1), .pass2(pass2), .last_dev(last_dev),
        .tg_busy(tg_busy), .tg_result(tg_result),
        .out1(out1), .out2(out2), .od_mode(od_mode),
        .slot_go(slot_go), .slot_cmd(slot_cmd)
    );

    function automatic logic [1:0] exp_pass(logic p1, logic p2, logic last, logic en);
        return (last && !en) ? 2'b11 : {p1, p2};
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // code: 0 bit-high, 1 write-0, 2 reset, 3 overdrive toggle
    task automatic run_cmd(int code, logic res, logic last, logic p1, logic p2, bit retrig);
        logic [1:0] pe;
        rsel = (code < 2); dclk = (code == 0 || code == 2);
        last_dev = last; pass1 = p1; pass2 = p2; en_n = 1'b1;
        step();
        en_n = 1'b0;
        step();
        pe = exp_pass(p1, p2, last, 1'b0);
        if (code == 3) begin
            exp_od = ~exp_od;
            check("R7 toggle od/go", {2'b00, od_mode, slot_go}, {2'b00, exp_od, 1'b0});
            check("R7 toggle report", {2'b00, out1, out2}, {2'b00, exp_od ? pe : 2'b00});
        end else begin
            check("R1 go/cmd", {1'b0, slot_go, slot_cmd}, {1'b0, 1'b1, 2'(code)});
            tg_busy = 1'b1;
            if (code == 2) begin
                check("R2 split start", {2'b00, out1, out2}, 4'b0001);
                repeat (SPLIT - 1) step();
                check("R2 split end", {2'b00, out1, out2}, 4'b0001);
                step();
                check("R2 both low", {2'b00, out1, out2}, 4'b0000);
            end else begin
                check("R3 bit busy", {2'b00, out1, out2}, 4'b0000);
                repeat (3) step();
                if (retrig) begin
                    en_n = 1'b1; step();
                    en_n = 1'b0; step();
                    check("R9 retrigger ignored", {slot_go, od_mode, out1, out2},
                          {1'b0, exp_od, 2'b00});
                end
                check("R3 bit hold", {2'b00, out1, out2}, 4'b0000);
            end
            tg_result = res; tg_busy = 1'b0;
            step();
            check(last ? "R8 last-device completion" : "R4 completion",
                  {2'b00, out1, out2}, {2'b00, pe});
            dclk = 1'b0;
            step();
            check("R5 query", {2'b00, out1, out2}, {2'b00, res ? pe : 2'b00});
            tg_result = 1'b1;
        end
        en_n = 1'b1; dclk = 1'b1;
        step();
        check("R6 release", {2'b00, out1, out2}, {2'b00, p1, p2});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) step();
        check("R10 reset", {1'b0, od_mode, slot_go, 1'b0}, 4'b0000);
        rst = 1'b0;
        pass1 = 1'b0; pass2 = 1'b1; #1;
        check("R10 pass after reset", {2'b00, out1, out2}, 4'b0001);
        // idle pass-through is combinational
        for (int i = 0; i < 8; i++) begin
            step();
            pass1 = $urandom; pass2 = $urandom; #1;
            check("R6 idle pass", {2'b00, out1, out2}, {2'b00, pass1, pass2});
        end
        // directed corners
        run_cmd(2, 1'b0, 1'b0, 1'b1, 1'b0, 0);   // reset, presence (low result)
        run_cmd(0, 1'b1, 1'b1, 1'b0, 1'b0, 1);   // last device, high result, re-trigger
        run_cmd(1, 1'b0, 1'b0, 1'b1, 1'b1, 0);   // write 0
        run_cmd(3, 1'b0, 1'b0, 1'b1, 1'b0, 0);   // overdrive on
        run_cmd(3, 1'b0, 1'b1, 1'b1, 1'b0, 0);   // overdrive off
        // random mix
        for (int i = 0; i < 40; i++) begin
            run_cmd($urandom % 4, 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule